// File: doc/BRIEF.md
# Dual-Compare Timer with Pulse Output

This block is an 8-bit up-counter. A prescaled enable from the system clock advances it. Two compare registers watch the count. When the count equals a compare value on an advance cycle, three things happen. A status flag is raised. A two-bit action for that compare may set, clear or toggle a single output pin. A programmable field may send the counter back to zero. If one compare clears the counter and the other one flips the pin, the pin carries a pulse train with any period and duty.

A wrap from the all-ones count to zero raises a third flag. Each flag has its own enable, and the enabled flags are ORed into one interrupt request. Software reaches every register through a small synchronous read/write port. A flag is cleared by writing zero to it after it has been read as one. A low-power input returns every register, the prescaler and the pin to their reset state for as long as it is held.

Top module: `dual_cmp_timer`

## Requirements
- R1: While rst_n is low or lp_hold is high at a clock edge, all registers, the counter, the prescaler and tmr_out return to 0 after that edge, and irq is 0.
- R2: The counter advances on the edges that follow enabled cycles. The clock-select bits DIV (CTL0[2:0]) and FAST (CTL1[0]) choose those cycles. DIV=000 or 111 stops the counter. For DIV=n in 1..6 with FAST=0, the counter advances once every 2^(n+1) system clocks. For DIV=n in 1..6 with FAST=1, it advances on every clock.
- R3: An advance from 0xFF sets the overflow flag (STAT[5]) and wraps the count to 0x00. This applies unless a compare clear takes effect at that edge.
- R4: If the count equals CMPA (or CMPB) on an enabled cycle, STAT[6] (or STAT[7]) is set at the next edge.
- R5: CTL0[4:3] picks the clear source: 00 = free-running, 01 = clear on a match with CMPA, 10 = clear on a match with CMPB, 11 = free-running. The clear takes effect on the same edge that sets the flag.
- R6: STAT[1:0] gives the pin action for a match with CMPA, and STAT[3:2] gives it for a match with CMPB. The codes are 00 = keep, 01 = drive 0, 10 = drive 1, 11 = toggle. With STAT[3:0]=0110 and clear on CMPA, the pin is high from the CMPA match until the CMPB match.
- R7: If both compares match on the same enabled cycle, only the CMPB action is applied.
- R8: A flag is cleared only when a write to STAT carries 0 in its bit and an earlier read of STAT returned 1 in that bit. Writing 0 with no such read, or writing 1, leaves the flag unchanged.
- R9: irq is high exactly when some flag is set and its enable is set. The enables are CTL0[6] for CMPA, CTL0[7] for CMPB and CTL0[5] for overflow.
- R10: The register addresses are 0 = CNT, 1 = CTL0, 2 = CTL1 (bit 0 only), 3 = CMPA, 4 = CMPB and 5 = STAT. Reads of unused bits and addresses return 0. Software writes to STAT bits 7..4 are ignored. A write to CNT overrides counting on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_hold | input | 1 | High in low-power modes; holds the whole timer in reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of STAT arms flag clearing |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that bus_wr and bus_rd are single-cycle strobes with a stable address. They also assume that lp_hold is driven synchronously, like a reset. The counter-clear and wrap properties are excused on cycles where software writes CNT, because that write is allowed to override them. The bench drives every input half a cycle away from the active edge and issues at most one bus operation per cycle. It pulses lp_hold before each scenario, so that the reference model starts from the known reset state.

// File: rtl/dct_pkg.sv
// Shared constants and types for the dual-compare timer.
// Assumes 8-bit registers and a 3-bit register address.
package dct_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    // Index of each flag in the flag vector {b, a, ovf}
    localparam int F_OVF = 0;
    localparam int F_A   = 1;
    localparam int F_B   = 2;
    localparam int N_FLAGS = 3;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_A    = 2'b01,
        CLR_B    = 2'b10,
        CLR_RSV  = 2'b11
    } clr_src_e;

endpackage

// File: rtl/dct_prescaler.sv
// Prescaler: a free-running divider that yields a one-cycle count enable.
// Assumes div_sel 1..DIV_STEPS selects division by 2^(div_sel+1) and any
// other value stops counting. fast bypasses division for a valid selection.
module dct_prescaler #(
    parameter int DIV_STEPS = 6,
    localparam int PW = DIV_STEPS + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_hold,
    input  logic [2:0] div_sel,
    input  logic       fast,
    output logic       tick
);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;
    logic          sel_ok;

    // Free-running divider stage, cleared in reset and low power
    always_ff @(posedge clk) begin
        if (!rst_n || lp_hold) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    // Build the low-bit mask whose all-ones state marks the enable cycle
    always_comb begin
        mask = '0;
        for (int i = 0; i < PW; i++) begin
            if (i <= int'(div_sel)) mask[i] = 1'b1;
        end
    end

    // Valid selection window and the resulting enable
    always_comb begin
        sel_ok = (int'(div_sel) >= 1) && (int'(div_sel) <= DIV_STEPS);
        tick   = sel_ok && (fast || (&(pre_q | ~mask)));
    end

endmodule

// File: rtl/dct_counter.sv
// Counter core: up-counter, compare detection, clear source and wrap event.
// Assumes a software write has priority over counting on the same edge.
module dct_counter
    import dct_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_hold,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    input  logic [1:0]    clr_sel,
    output logic [DW-1:0] cnt,
    output logic          hit_a,
    output logic          hit_b,
    output logic          wrap
);

    logic clr_now;

    // Match detection and clear decision for the current cycle
    always_comb begin
        hit_a = tick && (cnt == cmp_a);
        hit_b = tick && (cnt == cmp_b);
        unique case (clr_src_e'(clr_sel))
            CLR_A:   clr_now = hit_a;
            CLR_B:   clr_now = hit_b;
            default: clr_now = 1'b0;
        endcase
        wrap = tick && (&cnt) && !clr_now;
    end

    // Count register: write, clear or increment
    always_ff @(posedge clk) begin
        if (!rst_n || lp_hold) cnt <= '0;
        else if (cnt_wr)       cnt <= wdata;
        else if (tick)         cnt <= clr_now ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/dct_pin.sv
// Output pin control: applies the per-compare action, match B winning.
// Assumes hit_a and hit_b are single-cycle match strobes.
module dct_pin
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_hold,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic [1:0] act_a,
    input  logic [1:0] act_b,
    output logic       pin
);

    logic [1:0] act;
    logic       nxt;

    // Pick the governing action and compute the next pin level
    always_comb begin
        act = hit_b ? act_b : (hit_a ? act_a : ACT_KEEP);
        unique case (pin_act_e'(act))
            ACT_LOW:  nxt = 1'b0;
            ACT_HIGH: nxt = 1'b1;
            ACT_TOG:  nxt = ~pin;
            default:  nxt = pin;
        endcase
    end

    // Pin register
    always_ff @(posedge clk) begin
        if (!rst_n || lp_hold) pin <= 1'b0;
        else                   pin <= nxt;
    end

endmodule

// File: rtl/dct_regs.sv
// Register file: control, compare and status registers, and the flags
// with their read-then-write-zero clearing. Assumes one access per cycle.
module dct_regs
    import dct_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_hold,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [DW-1:0]      cnt,
    input  logic [N_FLAGS-1:0] evt,
    output logic               cnt_wr,
    output logic [2:0]         div_sel,
    output logic               fast,
    output logic [1:0]         clr_sel,
    output logic [N_FLAGS-1:0] ien,
    output logic [DW-1:0]      cmp_a,
    output logic [DW-1:0]      cmp_b,
    output logic [1:0]         act_a,
    output logic [1:0]         act_b,
    output logic [N_FLAGS-1:0] flag
);

    logic [DW-1:0]      ctl0_q;
    logic               ctl1_q;
    logic [3:0]         osel_q;
    logic [N_FLAGS-1:0] arm_q;
    logic               wr_stat;
    logic               rd_stat;
    logic [N_FLAGS-1:0] stat_bits;

    assign cnt_wr   = bus_wr && (bus_addr == A_CNT);
    assign wr_stat  = bus_wr && (bus_addr == A_STAT);
    assign rd_stat  = bus_rd && (bus_addr == A_STAT);
    assign div_sel  = ctl0_q[2:0];
    assign clr_sel  = ctl0_q[4:3];
    assign ien      = ctl0_q[7:5];
    assign fast     = ctl1_q;
    assign act_a    = osel_q[1:0];
    assign act_b    = osel_q[3:2];
    assign stat_bits = bus_wdata[7:5];

    // Writable control, compare and output-select registers
    always_ff @(posedge clk) begin
        if (!rst_n || lp_hold) begin
            ctl0_q <= '0;
            ctl1_q <= 1'b0;
            cmp_a  <= '0;
            cmp_b  <= '0;
            osel_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTL0:  ctl0_q <= bus_wdata;
                A_CTL1:  ctl1_q <= bus_wdata[0];
                A_CMPA:  cmp_a  <= bus_wdata;
                A_CMPB:  cmp_b  <= bus_wdata;
                A_STAT:  osel_q <= bus_wdata[3:0];
                default: ;
            endcase
        end
    end

    // One flag and its clear-arm bit per event source
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        // Set on event; clear on a zero write after a read returned one
        always_ff @(posedge clk) begin
            if (!rst_n || lp_hold) begin
                flag[g]  <= 1'b0;
                arm_q[g] <= 1'b0;
            end else if (evt[g]) begin
                flag[g] <= 1'b1;
            end else if (wr_stat && !stat_bits[g] && arm_q[g]) begin
                flag[g]  <= 1'b0;
                arm_q[g] <= 1'b0;
            end else if (rd_stat) begin
                arm_q[g] <= flag[g];
            end
        end
    end

    // Read data selection
    always_comb begin
        unique case (bus_addr)
            A_CNT:   bus_rdata = cnt;
            A_CTL0:  bus_rdata = ctl0_q;
            A_CTL1:  bus_rdata = {{(DW-1){1'b0}}, ctl1_q};
            A_CMPA:  bus_rdata = cmp_a;
            A_CMPB:  bus_rdata = cmp_b;
            A_STAT:  bus_rdata = {flag, 1'b0, osel_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_cmp_timer.sv
// Top of the dual-compare timer: prescaler, counter, pin control and
// register file. Assumes lp_hold is synchronous to clk.
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DIV_STEPS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_hold,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              tmr_out,
    output logic              irq
);

    logic               tick;
    logic               cnt_wr;
    logic [2:0]         div_sel;
    logic               fast;
    logic [1:0]         clr_sel;
    logic [N_FLAGS-1:0] ien;
    logic [N_FLAGS-1:0] flag;
    logic [N_FLAGS-1:0] evt;
    logic [DW-1:0]      cmp_a;
    logic [DW-1:0]      cmp_b;
    logic [DW-1:0]      cnt;
    logic [1:0]         act_a;
    logic [1:0]         act_b;
    logic               hit_a;
    logic               hit_b;
    logic               wrap;

    dct_prescaler #(.DIV_STEPS(DIV_STEPS)) u_pre (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold),
        .div_sel(div_sel), .fast(fast), .tick(tick)
    );

    dct_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .tick(tick),
        .cnt_wr(cnt_wr), .wdata(bus_wdata), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .clr_sel(clr_sel), .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b),
        .wrap(wrap)
    );

    dct_pin u_pin (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .hit_a(hit_a),
        .hit_b(hit_b), .act_a(act_a), .act_b(act_b), .pin(tmr_out)
    );

    // Event vector in flag order {b, a, ovf}
    assign evt = {hit_b, hit_a, wrap};

    dct_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt(cnt), .evt(evt), .cnt_wr(cnt_wr),
        .div_sel(div_sel), .fast(fast), .clr_sel(clr_sel), .ien(ien),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .act_a(act_a), .act_b(act_b),
        .flag(flag)
    );

    // Combined interrupt request
    assign irq = |(flag & ien);

endmodule

// File: rtl/dct_checker.sv
// Property checker for the dual-compare timer, attached by bind.
module dct_checker
    import dct_pkg::*;
#(
    parameter int DW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lp_hold,
    input logic               tick,
    input logic               cnt_wr,
    input logic [DW-1:0]      cnt,
    input logic [2:0]         div_sel,
    input logic [1:0]         clr_sel,
    input logic               hit_a,
    input logic               hit_b,
    input logic [1:0]         act_b,
    input logic [N_FLAGS-1:0] flag,
    input logic               tmr_out,
    input logic               irq
);

    a_r1_lp_reset: assert property (@(posedge clk) disable iff (!rst_n)
        lp_hold |=> (cnt == '0) && !tmr_out && !irq);

    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        ((div_sel == 3'b000) && !cnt_wr && !lp_hold) |=> $stable(cnt));

    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cnt) && !cnt_wr && !lp_hold) |=> (cnt == '0));

    a_r4_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !lp_hold) |=> flag[F_A]);

    a_r4_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && !lp_hold) |=> flag[F_B]);

    a_r5_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && (clr_sel == CLR_A) && !cnt_wr && !lp_hold) |=> (cnt == '0));

    a_r6_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_a && !hit_b && !lp_hold) |=> $stable(tmr_out));

    a_r7_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && hit_b && (act_b == ACT_HIGH) && !lp_hold) |=> tmr_out);

endmodule

bind dual_cmp_timer dct_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .tick(tick),
    .cnt_wr(cnt_wr), .cnt(cnt), .div_sel(div_sel), .clr_sel(clr_sel),
    .hit_a(hit_a), .hit_b(hit_b), .act_b(act_b), .flag(flag),
    .tmr_out(tmr_out), .irq(irq)
);

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_hold = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tmr_out;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [2:0] CNT = 3'd0, CTL0 = 3'd1, CTL1 = 3'd2,
                           CMPA = 3'd3, CMPB = 3'd4, STAT = 3'd5;

    always #4 clk = ~clk;

    dual_cmp_timer u_dual_cmp_timer (
        .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic lp_pulse();
        @(negedge clk);
        lp_hold = 1'b1;
        @(posedge clk);
        #1 lp_hold = 1'b0;
    endtask

    // Pin action from the requirement encoding
    function automatic logic apply_act(input logic [1:0] act, input logic p);
        case (act)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~p;
            default: return p;
        endcase
    endfunction

    // Expected advance count over a window for a clock selection
    function automatic int exp_adv(input int dsel, input bit fst, input int win);
        if (dsel < 1 || dsel > 6) return 0;
        if (fst) return win % 256;
        return (win >> (dsel + 1)) % 256;
    endfunction

    task automatic measure(input int dsel, input bit fst, input int win);
        logic [7:0] c1, c2;
        wr(CTL1, {7'd0, fst});
        wr(CTL0, {5'd0, 3'(dsel)});
        rd(CNT, c1);
        repeat (win - 1) @(posedge clk);
        rd(CNT, c2);
        check($sformatf("R2 div=%0d fast=%0d", dsel, fst),
              int'(8'(c2 - c1)), exp_adv(dsel, fst, win));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 and R10: reset state
        @(negedge clk);
        check("R1 pin after reset", int'(tmr_out), 0);
        check("R1 irq after reset", int'(irq), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check($sformatf("R1 reg %0d after reset", a), int'(v), 0);
        end

        // R10: register map readback
        wr(CTL0, 8'hFF); wr(CTL1, 8'hFF); wr(CMPA, 8'h5A);
        wr(CMPB, 8'hA5); wr(STAT, 8'hFF);
        rd(CTL0, v); check("R10 CTL0", int'(v), 8'hFF);
        rd(CTL1, v); check("R10 CTL1", int'(v), 8'h01);
        rd(CMPA, v); check("R10 CMPA", int'(v), 8'h5A);
        rd(CMPB, v); check("R10 CMPB", int'(v), 8'hA5);
        rd(STAT, v); check("R10 STAT upper ignored", int'(v), 8'h0F);
        rd(3'd7, v); check("R10 unused addr", int'(v), 0);

        // R1: low-power hold clears registers
        lp_pulse();
        rd(CTL0, v); check("R1 CTL0 after lp_hold", int'(v), 0);
        rd(CMPB, v); check("R1 CMPB after lp_hold", int'(v), 0);
        rd(STAT, v); check("R1 STAT after lp_hold", int'(v), 0);

        // R2: clock selection rates
        for (int d = 0; d < 8; d++) measure(d, 1'b0, 512);
        measure(3, 1'b1, 100);
        measure(0, 1'b1, 100);

        // R3, R9, R8: overflow flag, enable and clear protocol
        lp_pulse();
        wr(CTL1, 8'h01);
        wr(CNT, 8'hFD);
        wr(CTL0, 8'b0010_0001);
        repeat (2) @(posedge clk);
        @(negedge clk); check("R9 irq before overflow", int'(irq), 0);
        @(posedge clk);
        @(negedge clk); check("R3 overflow raises irq", int'(irq), 1);
        wr(CTL0, 8'b0010_0000);
        wr(STAT, 8'h00);
        @(negedge clk); check("R8 write 0 without read", int'(irq), 1);
        rd(STAT, v); check("R3 overflow flag bit", int'(v[5]), 1);
        wr(STAT, 8'h00);
        @(negedge clk); check("R8 clear after read", int'(irq), 0);
        wr(STAT, 8'hE0);
        rd(STAT, v); check("R8 write 1 no set", int'(v[5]), 0);

        // R4, R9, R5: compare A flag timing, free-running count
        lp_pulse();
        wr(CMPA, 8'd5);
        wr(CTL1, 8'h01);
        wr(CTL0, 8'b0100_0001);
        repeat (5) @(posedge clk);
        @(negedge clk); check("R4 no flag before match edge", int'(irq), 0);
        @(posedge clk);
        @(negedge clk); check("R4 flag A after match", int'(irq), 1);
        rd(CNT, v); check("R5 clear 00 keeps counting", int'(v), 7);

        // R6: 0110 pulse with clear on A
        lp_pulse();
        wr(CMPA, 8'd9); wr(CMPB, 8'd3); wr(STAT, 8'h06); wr(CTL1, 8'h01);
        wr(CTL0, 8'b0000_1001);
        repeat (9) @(posedge clk);
        @(negedge clk); check("R6 low before A match", int'(tmr_out), 0);
        @(posedge clk);
        @(negedge clk); check("R6 high on A match", int'(tmr_out), 1);
        repeat (3) @(posedge clk);
        @(negedge clk); check("R6 high until B", int'(tmr_out), 1);
        @(posedge clk);
        @(negedge clk); check("R6 low on B match", int'(tmr_out), 0);
        repeat (6) @(posedge clk);
        @(negedge clk); check("R5 R6 period after clear on A", int'(tmr_out), 1);

        // R7: simultaneous matches, B action wins
        for (int k = 0; k < 2; k++) begin
            lp_pulse();
            wr(CMPA, 8'd4); wr(CMPB, 8'd4);
            wr(STAT, (k == 0) ? 8'h06 : 8'h09);
            wr(CTL1, 8'h01);
            wr(CTL0, 8'b0000_0001);
            repeat (5) @(posedge clk);
            @(negedge clk);
            check($sformatf("R7 B priority case %0d", k), int'(tmr_out), k);
        end

        // R5 R6 R7 R4: random configurations against the bench model
        for (int run = 0; run < 24; run++) begin
            logic [7:0] ca, cb, m_cnt;
            logic [3:0] os;
            logic [1:0] cs;
            logic m_out, ma, mb, clr, seen_a;
            ca = 8'($urandom_range(2, 40));
            cb = (run % 4 == 0) ? ca : 8'($urandom_range(1, 40));
            os = 4'($urandom);
            cs = 2'($urandom);
            lp_pulse();
            wr(CMPA, ca); wr(CMPB, cb); wr(STAT, {4'd0, os});
            wr(CTL1, 8'h01);
            wr(CTL0, {3'b000, cs, 3'b001});
            m_cnt = 8'd0; m_out = 1'b0; seen_a = 1'b0;
            for (int c = 0; c < 120; c++) begin
                @(posedge clk);
                ma = (m_cnt == ca); mb = (m_cnt == cb);
                seen_a = seen_a | ma;
                clr = (cs == 2'b01 && ma) || (cs == 2'b10 && mb);
                if (mb) m_out = apply_act(os[3:2], m_out);
                else if (ma) m_out = apply_act(os[1:0], m_out);
                m_cnt = clr ? 8'd0 : m_cnt + 8'd1;
                @(negedge clk);
                if (c % 10 == 9 || ma || mb)
                    check($sformatf("R6 R5 random run %0d cycle %0d", run, c),
                          int'(tmr_out), int'(m_out));
            end
            rd(STAT, v);
            check($sformatf("R4 random flag A run %0d", run), int'(v[6]), int'(seen_a));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule